// File: doc/BRIEF.md
# Ethernet Receive Frame Check

This block validates the frame check sequence of an incoming Ethernet frame one byte at a time. Bytes come in after the start-of-frame delimiter, each marked by a strobe, while a frame-active input is high. In serial operation that input follows carrier sense. In parallel operation it follows the receive data-valid signal. The block keeps a 32-bit running CRC over every byte of the frame, the FCS bytes included. A frame with an intact FCS leaves a fixed residue in the register, so the block never has to pick out the FCS field.

When frame-active drops, the block compares the register with the residue and raises a one-cycle pass or fail pulse. In parallel mode, a receive-error indication at any point during the frame forces a fail, whatever the residue is. The running CRC is also driven out in polynomial (MSB-first) order, so address-filter logic can take a snapshot of it part way through the frame. Partial trailing bytes never reach this block as strobed bytes, so they are dropped by construction.

Top module: `eth_rx_fcs_check`

## Requirements
- R1: After reset, `crc_ok` and `crc_err` are 0 and `crc_run` reads 32'hFFFFFFFF.
- R2: On the first cycle that `frame_act` is high after being low, the CRC register is preset to all ones. With no strobed byte in that cycle, `crc_run` reads 32'hFFFFFFFF on the next cycle.
- R3: Each byte strobed while `frame_act` is high updates the CRC with polynomial 32'h04C11DB7. Bit 0 of the byte is processed first. The new `crc_run`, presented in polynomial order (bit 31 = x^31 coefficient), appears one cycle after the strobe.
- R4: While `frame_act` is low, strobed bytes are ignored and `crc_run` does not change.
- R5: One cycle after `frame_act` falls, exactly one of `crc_ok`/`crc_err` pulses high for one cycle. `crc_ok` is chosen only when the final `crc_run` equals 32'hC704DD7B and no forced error is pending.
- R6: With `par_mode` = 1, `rx_err` high in any cycle where `frame_act` is high forces `crc_err` at the end of that frame.
- R7: With `par_mode` = 0, `rx_err` has no effect on the result.
- R8: A forced error is cleared when the next frame starts, so it does not carry into the next frame.
- R9: `rx_err` asserted while `frame_act` is low has no effect on the next frame's result.
- R10: A cycle with `frame_act` high and no byte strobe leaves `crc_run` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| par_mode | input | 1 | 1 = parallel (data-valid framing, receive error honoured), 0 = serial |
| frame_act | input | 1 | Frame active: carrier (serial) or data valid (parallel) |
| rx_err | input | 1 | Receive error indication |
| byte_vld | input | 1 | Strobe for `byte_in` |
| byte_in | input | 8 | Received byte, bit 0 first on the line |
| crc_run | output | 32 | Running CRC in polynomial order |
| crc_ok | output | 1 | One-cycle frame-good pulse |
| crc_err | output | 1 | One-cycle frame-bad pulse |

## Verification
On every cycle, the assertions check four things. The pass and fail pulses are mutually exclusive, last one cycle, and follow each end of frame. The register is preset at frame start. The CRC holds steady when the frame is idle or no byte is strobed. Some behaviour only the bench scenarios can show. These are the arithmetic of the CRC update and the residue decision on good frames of every length, single-bit corruptions, and receive errors at each byte position in both modes. They also include the way a forced error is scoped to one frame.

// File: rtl/eth_rx_fcs_check.sv
module eth_rx_fcs_check #(
  parameter logic [31:0] POLY    = 32'h04C11DB7,
  parameter logic [31:0] RESIDUE = 32'hC704DD7B
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        par_mode,
  input  logic        frame_act,
  input  logic        rx_err,
  input  logic        byte_vld,
  input  logic [7:0]  byte_in,
  output logic [31:0] crc_run,
  output logic        crc_ok,
  output logic        crc_err
);

  function automatic logic [31:0] rev32(input logic [31:0] v);
    logic [31:0] r;
    for (int i = 0; i < 32; i++) r[i] = v[31-i];
    return r;
  endfunction

  localparam logic [31:0] POLY_R = rev32(POLY);

  function automatic logic [31:0] step(input logic [31:0] c, input logic [7:0] d);
    logic [31:0] r;
    r = c;
    for (int i = 0; i < 8; i++) r = (r >> 1) ^ ((r[0] ^ d[i]) ? POLY_R : 32'h0);
    return r;
  endfunction

  logic [31:0] crc_q;
  logic        act_q, bad_q;

  wire start   = frame_act & ~act_q;
  wire fin     = act_q & ~frame_act;
  wire err_hit = par_mode & rx_err & frame_act;
  wire [31:0] base = start ? 32'hFFFFFFFF : crc_q;

  assign crc_run = rev32(crc_q);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      crc_q   <= 32'hFFFFFFFF;
      act_q   <= 1'b0;
      bad_q   <= 1'b0;
      crc_ok  <= 1'b0;
      crc_err <= 1'b0;
    end else begin
      act_q <= frame_act;
      if (frame_act) crc_q <= byte_vld ? step(base, byte_in) : base;
      if (start) bad_q <= err_hit;
      else if (err_hit) bad_q <= 1'b1;
      crc_ok  <= fin & (crc_run == RESIDUE) & ~bad_q;
      crc_err <= fin & ~((crc_run == RESIDUE) & ~bad_q);
    end
  end

  p_excl_r5: assert property (@(posedge clk) disable iff (!rst_n) !(crc_ok && crc_err));
  p_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (crc_ok || crc_err) |=> !(crc_ok || crc_err));
  p_end_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (act_q && !frame_act) |=> (crc_ok || crc_err));
  p_preset_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_act && !act_q && !byte_vld) |=> (crc_run == 32'hFFFFFFFF));
  p_idle_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_act |=> $stable(crc_run));
  p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_act && act_q && !byte_vld) |=> $stable(crc_run));

endmodule

// File: tb/eth_rx_fcs_check_tb.sv
module eth_rx_fcs_check_tb;
  logic clk = 0, rst_n = 0, par_mode = 0, frame_act = 0, rx_err = 0, byte_vld = 0;
  logic [7:0] byte_in = 0;
  logic [31:0] crc_run;
  logic crc_ok, crc_err;
  int checks = 0, fails = 0;
  bit done = 0;

  always #2 clk = ~clk;

  eth_rx_fcs_check u_dut (.clk(clk), .rst_n(rst_n), .par_mode(par_mode), .frame_act(frame_act),
    .rx_err(rx_err), .byte_vld(byte_vld), .byte_in(byte_in), .crc_run(crc_run),
    .crc_ok(crc_ok), .crc_err(crc_err));

  function automatic logic [31:0] ref_step(input logic [31:0] c, input logic [7:0] d);
    logic [31:0] r;
    logic fb;
    r = c;
    for (int i = 0; i < 8; i++) begin
      fb = r[31] ^ d[i];
      r = r << 1;
      if (fb) r = r ^ 32'h04C11DB7;
    end
    return r;
  endfunction

  function automatic logic [31:0] flip32(input logic [31:0] v);
    logic [31:0] r;
    for (int i = 0; i < 32; i++) r[i] = v[31-i];
    return r;
  endfunction

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic send_frame(input int len, input int flip, input int errpos, input bit par, input bit gap);
    logic [7:0] buf_b [0:39];
    logic [31:0] c, fcs, exp;
    int n;
    bit exp_ok;
    n = len + 4;
    c = 32'hFFFFFFFF;
    for (int i = 0; i < len; i++) begin
      buf_b[i] = 8'($urandom);
      c = ref_step(c, buf_b[i]);
    end
    fcs = ~flip32(c);
    for (int k = 0; k < 4; k++) buf_b[len+k] = fcs[8*k +: 8];
    if (flip >= 0) buf_b[flip/8][flip%8] = ~buf_b[flip/8][flip%8];
    exp = 32'hFFFFFFFF;
    par_mode = par;
    for (int i = 0; i < n; i++) begin
      frame_act = 1; byte_vld = 1; byte_in = buf_b[i]; rx_err = (i == errpos);
      tick();
      exp = ref_step(exp, buf_b[i]);
      chk(crc_run == exp, "R3 running crc", crc_run, exp);
      if (gap && (i % 3 == 1)) begin
        byte_vld = 0; rx_err = 0; byte_in = ~byte_in;
        tick();
        chk(crc_run == exp, "R10 stall hold", crc_run, exp);
      end
    end
    frame_act = 0; byte_vld = 0; rx_err = 0;
    exp_ok = (flip < 0) && !(par && errpos >= 0 && errpos < n);
    tick();
    chk(crc_ok == exp_ok && crc_err == !exp_ok,
        par ? "R5/R6 end result" : "R5/R7 end result", {30'd0, crc_ok, crc_err}, {30'd0, exp_ok, !exp_ok});
    tick();
    chk(!crc_ok && !crc_err, "R5 one-cycle pulse", {30'd0, crc_ok, crc_err}, 32'd0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=%h expected=%h", 0, 1);
      $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [31:0] hold;
    repeat (3) tick();
    chk(crc_run == 32'hFFFFFFFF && !crc_ok && !crc_err, "R1 reset state", crc_run, 32'hFFFFFFFF);
    rst_n = 1;
    tick();

    for (int len = 0; len <= 24; len++) send_frame(len, -1, -1, len[0], len[1]);

    for (int b = 0; b < 80; b++) send_frame(6, b, -1, b[0], 0);

    for (int p = 0; p < 10; p++) begin
      send_frame(6, -1, p, 1, 0);
      send_frame(6, -1, p, 0, 0);
    end

    // R8: error frame then clean frame
    send_frame(8, -1, 3, 1, 0);
    send_frame(8, -1, -1, 1, 0);

    // R9: rx_err while idle in parallel mode
    par_mode = 1; rx_err = 1;
    repeat (3) tick();
    rx_err = 0;
    send_frame(5, -1, -1, 1, 0);

    // R4: strobes while idle
    hold = crc_run;
    for (int i = 0; i < 16; i++) begin
      byte_vld = 1; byte_in = 8'(i * 37 + 5);
      tick();
      chk(crc_run == hold, "R4 idle bytes ignored", crc_run, hold);
    end
    byte_vld = 0;

    // R2: empty frame presets and fails
    frame_act = 1;
    tick();
    chk(crc_run == 32'hFFFFFFFF, "R2 preset at start", crc_run, 32'hFFFFFFFF);
    frame_act = 0;
    tick();
    chk(crc_err && !crc_ok, "R5 empty frame fails", {30'd0, crc_ok, crc_err}, 32'd1);
    tick();

    done = 1;
    $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule